// File: doc/BRIEF.md
# Page-Load Buffer with Timed Commit

This block is the page-programming path of a byte-wide nonvolatile store. A host presents byte loads on a synchronous strobe bus with a 16-bit address and 8-bit data. Each accepted byte is placed into a 128-entry page buffer. Address bits 6:0 choose the slot, and the bits above them name the page. Loading stays open while each new byte follows the previous one closely enough. When the bus stays quiet for a whole timeout window, the block commits the page into its internal array. During the commit a busy flag is raised. A separate enable input, `load_en`, stands in for the command and protection logic that would normally qualify loads.

The commit copies the whole page in one internally timed cycle. Slots that received data take the buffered byte. Slots that received nothing are written as FFh, so no separate erase is needed. The destination is always the page of the most recent byte, whatever pages the earlier bytes named. The last accepted address and data are held on outputs so a neighbouring status block can build polling bits from them. Array reads are served outside the commit cycle only.

The controller has three states. `ST_IDLE` moves to `ST_LOAD` on an accepted load. `ST_LOAD` stays in `ST_LOAD` on each further load, which restarts the idle count. It moves to `ST_COMMIT` when the idle count expires. `ST_COMMIT` returns to `ST_IDLE` when its cycle count ends, and clears the buffer on that exit.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset `busy` and `rd_valid` are 0, `last_addr` and `last_data` are 0, and every array byte reads FFh.
- R2: A load is accepted only when `wr_en` and `load_en` are both 1 and `busy` is 0. The clock edge that accepts it also updates `last_addr` and `last_data` to that byte's address and data.
- R3: `busy` rises exactly `LOAD_TIMEOUT` clock edges after the last accepted load. A further load arriving within `LOAD_TIMEOUT` edges keeps the page-load cycle open, with no upper limit on the number of loads.
- R4: Once `busy` rises, it stays high for exactly `WRITE_CYCLES` clocks. Nothing shortens or extends it.
- R5: The whole buffer is written into the page of the last accepted byte. The array page index is `addr[7 +: log2(ARRAY_PAGES)]`, and higher address bits alias.
- R6: Loading a slot a second time in the same page-load cycle replaces its buffered byte.
- R7: Every slot not loaded during the page-load cycle is written as FFh, overwriting older content.
- R8: `rd_en` with `busy` low returns the array byte at `addr` on `rdata`, with `rd_valid` = 1, one clock later. `rd_en` with `busy` high gives `rd_valid` = 0.
- R9: Loads presented while `busy` is high are ignored and leave `last_addr` and `last_data` unchanged. The buffer is emptied when the commit ends, so no byte carries into the next page.
- R10: A strobe with `load_en` = 0 is ignored. It neither updates `last_addr` nor starts a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte-load strobe |
| load_en | input | 1 | Load qualifier from the command/protection logic |
| rd_en | input | 1 | Array read strobe |
| addr | input | 16 | Byte address for loads and reads |
| wdata | input | 8 | Load data |
| rdata | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid (one clock after `rd_en`) |
| busy | output | 1 | Internal write cycle in progress |
| last_addr | output | 16 | Address of last accepted byte |
| last_data | output | 8 | Data of last accepted byte |

## Verification
A load accepted at clock edge E appears on `last_addr` and `last_data` after E. With no further load, `busy` is low through edge E+`LOAD_TIMEOUT`-1 and high after E+`LOAD_TIMEOUT`. It then falls after edge E+`LOAD_TIMEOUT`+`WRITE_CYCLES`. A read strobed at an edge is due after that same edge. The bench drives and samples on the falling edge. It counts falling edges from the last load to place the no-early-busy samples, the rising-busy sample and the busy-length count at exactly those cycles. It then reads back each committed page byte by byte against a model that applies replacement, FFh fill and the last-page rule.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2
    } pcb_state_e;
endpackage

// File: rtl/pcb_interval_counter.sv
module pcb_interval_counter #(
    parameter int MAX_COUNT = 16,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (en && count != CW'(MAX_COUNT)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pcb_page_buffer.sv
module pcb_page_buffer #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int IW = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_byte
);
    logic [DATA_W-1:0] slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                filled_q[g] <= 1'b0;
            end else if (wr && wr_idx == IW'(g)) begin
                filled_q[g] <= 1'b1;
            end
        end
        always_ff @(posedge clk) begin
            if (wr && wr_idx == IW'(g)) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_byte = filled_q[rd_idx] ? slot_q[rd_idx] : {DATA_W{1'b1}};
    end
endmodule

// File: rtl/pcb_array.sv
module pcb_array #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= {DATA_W{1'b1}};
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cell_q[raddr];
        end
    end
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
    import pcb_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 128,
    parameter int ARRAY_PAGES  = 8,
    parameter int LOAD_TIMEOUT = 50,
    parameter int WRITE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              load_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int BW   = $clog2(PAGE_BYTES);
    localparam int PW   = $clog2(ARRAY_PAGES);
    localparam int AW   = BW + PW;
    localparam int TW   = $clog2(LOAD_TIMEOUT + 1);
    localparam int WW   = $clog2(WRITE_CYCLES + 1);

    pcb_state_e state_q, state_d;
    logic [TW-1:0] idle_cnt;
    logic [WW-1:0] wr_cnt;
    logic          load_ok, commit_done, idle_expired, arr_we, arr_re, buf_clr;
    logic [DATA_W-1:0] commit_byte;
    logic [PW-1:0] commit_page;

    assign load_ok      = wr_en && load_en && (state_q != ST_COMMIT);
    assign idle_expired = (idle_cnt == TW'(LOAD_TIMEOUT - 1));
    assign commit_done  = (wr_cnt == WW'(WRITE_CYCLES - 1));
    assign commit_page  = last_addr[BW +: PW];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load_ok) state_d = ST_LOAD;
            ST_LOAD:   if (!load_ok && idle_expired) state_d = ST_COMMIT;
            ST_COMMIT: if (commit_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs derived from state
    always_comb begin
        busy    = (state_q == ST_COMMIT);
        arr_we  = busy && (wr_cnt < WW'(PAGE_BYTES));
        arr_re  = rd_en && !busy;
        buf_clr = busy && commit_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            last_data <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= arr_re;
            if (load_ok) begin
                last_addr <= addr;
                last_data <= wdata;
            end
        end
    end

    pcb_interval_counter #(.MAX_COUNT(LOAD_TIMEOUT)) u_idle_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_ok || state_q != ST_LOAD),
        .en    (state_q == ST_LOAD),
        .count (idle_cnt)
    );

    pcb_interval_counter #(.MAX_COUNT(WRITE_CYCLES)) u_write_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_COMMIT),
        .en    (state_q == ST_COMMIT),
        .count (wr_cnt)
    );

    pcb_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (load_ok),
        .wr_idx  (addr[BW-1:0]),
        .wr_data (wdata),
        .clr     (buf_clr),
        .rd_idx  (wr_cnt[BW-1:0]),
        .rd_byte (commit_byte)
    );

    pcb_array #(.DEPTH(PAGE_BYTES * ARRAY_PAGES), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr ({commit_page, wr_cnt[BW-1:0]}),
        .wdata (commit_byte),
        .re    (arr_re),
        .raddr (addr[AW-1:0]),
        .rdata (rdata)
    );

    // R3: no commit before the idle window has fully elapsed
    a_r3_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && (load_ok || !idle_expired)) |=> !busy);

    // R4: commit is not cut short
    a_r4_commit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit_done) |=> busy);

    // R8: no array read result while busy
    a_r8_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);

    // R9: loads during commit leave the last-byte register untouched
    a_r9_last_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data)));

    // R2: an accepted load is captured on the next cycle
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && load_en && !busy) |=> (last_addr == $past(addr) && last_data == $past(wdata)));

    // R10: an unqualified strobe from idle does not open loading
    a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_en) |=> state_q == ST_IDLE);
endmodule

// File: tb/tb_page_commit_buffer.sv
module tb_page_commit_buffer;
    localparam int T  = 20;
    localparam int W  = 160;
    localparam int PB = 128;
    localparam int NP = 8;
    localparam int DEP = PB * NP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, load_en = 1'b0, rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rd_valid, busy;
    logic [15:0] last_addr;
    logic [7:0]  last_data;

    page_commit_buffer #(.PAGE_BYTES(PB), .ARRAY_PAGES(NP),
                         .LOAD_TIMEOUT(T), .WRITE_CYCLES(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .load_en(load_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .busy(busy),
        .last_addr(last_addr), .last_data(last_data));

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [7:0]  mem_m [DEP];
    logic [7:0]  bd_m [PB];
    logic        bv_m [PB];
    logic [15:0] last_m = '0;
    logic [7:0]  lastd_m = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic int midx(input logic [15:0] a);
        return int'(a[9:0]);
    endfunction

    task automatic load_byte(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; load_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; load_en = 1'b0;
        bd_m[a[6:0]] = d; bv_m[a[6:0]] = 1'b1;
        last_m = a; lastd_m = d;
        chk(last_addr == a && last_data == d, "R2 last byte capture", {last_addr, last_data}, {a, d});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called at the falling edge right after the last accepted load
    task automatic commit_and_check();
        int cnt;
        bit early;
        int base;
        early = 1'b0;
        for (int i = 0; i < T - 1; i++) begin
            @(negedge clk);
            if (busy) early = 1'b1;
        end
        chk(!early, "R3 busy before timeout", early, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R3 busy at timeout", busy, 1);
        wr_en = 1'b1; load_en = 1'b1; addr = last_m ^ 16'h0085; wdata = ~lastd_m; rd_en = 1'b1;
        cnt = 1;
        @(negedge clk);
        wr_en = 1'b0; load_en = 1'b0; rd_en = 1'b0;
        if (busy) cnt++;
        chk(rd_valid == 1'b0, "R8 read while busy", rd_valid, 0);
        chk(last_addr == last_m && last_data == lastd_m, "R9 load while busy",
            {last_addr, last_data}, {last_m, lastd_m});
        while (busy && cnt < 1000) begin
            @(negedge clk);
            if (busy) cnt++;
        end
        chk(cnt == W, "R4 busy length", cnt, W);
        base = midx({last_m[15:7], 7'd0});
        for (int i = 0; i < PB; i++) begin
            mem_m[base + i] = bv_m[i] ? bd_m[i] : 8'hFF;
            bv_m[i] = 1'b0;
        end
    endtask

    task automatic read_chk(input logic [15:0] a, input string req);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_valid == 1'b1 && rdata == mem_m[midx(a)], req, {rd_valid, rdata}, {1'b1, mem_m[midx(a)]});
    endtask

    task automatic page_chk(input logic [15:0] a, input string req);
        for (int i = 0; i < PB; i++) read_chk({a[15:7], 7'(i)}, req);
    endtask

    initial begin
        int seed, nl, g;
        logic [15:0] pa, a;
        seed = int'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEP; i++) mem_m[i] = 8'hFF;
        for (int i = 0; i < PB; i++) begin bv_m[i] = 1'b0; bd_m[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1 reset flags", {busy, rd_valid}, 0);
        chk(last_addr == 16'h0 && last_data == 8'h0, "R1 reset last byte", {last_addr, last_data}, 0);
        read_chk(16'h0000, "R1 erased array");
        read_chk(16'h03FF, "R1 erased array");

        // R10 strobe without load_en is ignored
        wr_en = 1'b1; load_en = 1'b0; addr = 16'h1234; wdata = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        idle(T + 2);
        chk(last_addr == 16'h0 && busy == 1'b0, "R10 gated strobe", {last_addr, busy}, 0);
        read_chk(16'h1234, "R10 array untouched");

        // R6 rewrite of a slot, gaps exactly at the window edge (R3)
        load_byte(16'h0105, 8'h11);
        idle(T - 1);
        load_byte(16'h0105, 8'h22);
        idle(T - 1);
        load_byte(16'h0110, 8'h33);
        commit_and_check();
        read_chk(16'h0105, "R6 replaced byte");
        page_chk(16'h0100, "R7 fill of page");

        // R7/R9 single byte into the same page: old bytes become FF
        load_byte(16'h0120, 8'h44);
        commit_and_check();
        page_chk(16'h0100, "R7 R9 refill");

        // R5 bytes loaded under page A, last under page B
        load_byte(16'h0203, 8'hA1);
        idle(3);
        load_byte(16'h0207, 8'hA2);
        idle(2);
        load_byte(16'h0311, 8'hB3);
        commit_and_check();
        page_chk(16'h0300, "R5 target page");
        page_chk(16'h0200, "R5 other page untouched");

        // Random rounds
        for (int r = 0; r < 10; r++) begin
            pa = 16'($urandom) & 16'hFF80;
            nl = 1 + int'($urandom_range(0, 11));
            for (int k = 0; k < nl; k++) begin
                a = pa | 16'($urandom_range(0, PB - 1));
                if (k == nl - 1 && $urandom_range(0, 3) == 0) a = a ^ 16'h0080;
                load_byte(a, 8'($urandom));
                if (k != nl - 1) begin
                    g = int'($urandom_range(1, T));
                    idle(g - 1);
                end
            end
            commit_and_check();
            page_chk(last_m, "R5 R6 R7 random page");
        end
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        report();
    end
endmodule